// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This block multiplies two signed Q15 fractions into a Q31 value and folds that value into a 32-bit accumulator register. On each request one operation is chosen: clear the accumulator, load the product, add the product, or subtract it. The Q31 product is the signed integer product doubled. Every step saturates to the signed 32-bit range instead of wrapping, including the one product that cannot be represented (-1 × -1).

Alongside the accumulator the block presents a Q15 view of it, rounded to nearest by adding half an LSB of the upper half. It also registers a 16-bit fractional product of the current operands and keeps a sticky flag that records any saturation since the last clear. Each request is taken in one cycle and its result is marked valid on the following clock.

Top module: `sat_mac_unit`

## Requirements
- R1: After reset, valid_o, ovf_o, acc_o, rnd_o and frac_o are all zero.
- R2: valid_o is high in exactly the cycle after a cycle in which start_i is high, and low otherwise.
- R3: Op code 1 (load) sets acc_o to the signed product a_i×b_i doubled; when both operands are 0x8000 the result is 0x7FFFFFFF and ovf_o is set.
- R4: Op code 2 (add) sets acc_o to acc_o plus the Q31 product, saturated to 0x7FFFFFFF or 0x80000000 when both addends share a sign that the sum lacks.
- R5: Op code 3 (subtract) sets acc_o to acc_o minus the Q31 product, saturating only when the two signs differ and the result's sign differs from the old accumulator's.
- R6: Op code 0 (clear) sets acc_o to zero and clears ovf_o.
- R7: rnd_o is bits 31:16 of the saturated sum acc_o + 0x8000.
- R8: On every accepted request frac_o becomes bits 30:15 of the signed product, and 0x7FFF when both operands are 0x8000.
- R9: ovf_o, once set by a product clamp or accumulate saturation, stays set until a clear op.
- R10: While start_i is low, acc_o, frac_o and ovf_o hold their values whatever op_i, a_i and b_i carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one op per high cycle |
| op_i | input | 2 | 0 clear, 1 load, 2 add, 3 subtract |
| a_i | input | 16 | Q15 operand A |
| b_i | input | 16 | Q15 operand B |
| valid_o | output | 1 | Result of the previous request is present |
| acc_o | output | 32 | Q31 accumulator |
| rnd_o | output | 16 | Accumulator rounded to Q15 |
| frac_o | output | 16 | Q15 product of the last request's operands |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
Loads are tried with positive, negative, mixed-sign and full-scale operands, which separates a correct doubling from an undoubled or mis-signed product and exposes the lone -1 × -1 clamp. Add and subtract chains are driven into both rails, and a subtract of a negative product from the negative rail checks that subtract does not saturate when the signs agree. Rounding is checked at a value whose lower half is exactly one half and at the positive rail, where the rounding add itself must saturate. Idle cycles with changing operands show that nothing moves without a request.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_ADD   = 2'd2,
        OP_SUB   = 2'd3
    } mac_op_e;
endpackage

// File: rtl/q15_mul.sv
module q15_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic [2*DW-1:0] prod_o,
    output logic [DW-1:0]   frac_o,
    output logic            clamp_o
);
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] CLAMP_RAW = AW'(1) << (AW - 2);
    localparam logic [AW-1:0] AW_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [DW-1:0] DW_MAX = {1'b0, {(DW-1){1'b1}}};

    logic signed [AW-1:0] raw;

    always_comb begin
        raw     = $signed(a_i) * $signed(b_i);
        clamp_o = (raw == CLAMP_RAW);
        // Doubling only overflows for full-scale negative squared.
        prod_o  = clamp_o ? AW_MAX : {raw[AW-2:0], 1'b0};
        frac_o  = clamp_o ? DW_MAX : raw[AW-2:DW-1];
    end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam logic [W-1:0] W_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] W_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         sign_rule;

    always_comb begin
        raw       = sub_i ? (x_i - y_i) : (x_i + y_i);
        sign_rule = sub_i ? (x_i[W-1] != y_i[W-1]) : (x_i[W-1] == y_i[W-1]);
        sat_o     = sign_rule && (raw[W-1] != x_i[W-1]);
        res_o     = sat_o ? (x_i[W-1] ? W_MIN : W_MAX) : raw;
    end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [1:0]      op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    output logic            valid_o,
    output logic [2*DW-1:0] acc_o,
    output logic [DW-1:0]   rnd_o,
    output logic [DW-1:0]   frac_o,
    output logic            ovf_o
);
    import sat_mac_pkg::*;

    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] HALF_LSB = AW'(1) << (DW - 1);
    localparam logic [AW-1:0] AW_MAX = {1'b0, {(AW-1){1'b1}}};
    localparam logic [DW-1:0] FULL_NEG = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] acc;
        logic [DW-1:0] frac;
        logic          ovf;
    } mac_state_t;

    mac_state_t st_d, st_q;
    mac_op_e    op_sel;

    logic [AW-1:0] prod_w;
    logic [DW-1:0] frac_w;
    logic          clamp_w;
    logic [AW-1:0] accum_w;
    logic          accum_sat_w;
    logic [AW-1:0] round_w;
    logic          round_sat_w;

    assign op_sel = mac_op_e'(op_i);

    q15_mul #(.DW(DW)) mul_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod_w),
        .frac_o (frac_w),
        .clamp_o(clamp_w)
    );

    sat_addsub #(.W(AW)) accum_i (
        .x_i  (st_q.acc),
        .y_i  (prod_w),
        .sub_i(op_sel == OP_SUB),
        .res_o(accum_w),
        .sat_o(accum_sat_w)
    );

    sat_addsub #(.W(AW)) round_i (
        .x_i  (st_q.acc),
        .y_i  (HALF_LSB),
        .sub_i(1'b0),
        .res_o(round_w),
        .sat_o(round_sat_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        if (start_i) begin
            st_d.frac = frac_w;
            unique case (op_sel)
                OP_CLEAR: begin
                    st_d.acc = '0;
                    st_d.ovf = 1'b0;
                end
                OP_LOAD: begin
                    st_d.acc = prod_w;
                    st_d.ovf = st_q.ovf | clamp_w;
                end
                default: begin
                    st_d.acc = accum_w;
                    st_d.ovf = st_q.ovf | clamp_w | accum_sat_w;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign acc_o   = st_q.acc;
    assign frac_o  = st_q.frac;
    assign ovf_o   = st_q.ovf;
    assign rnd_o   = round_w[AW-1:DW];

    // R2: result strobe follows the request by one clock
    a_r2_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);
    // R3: full-scale negative squared clamps and flags
    a_r3_clamp_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 2'd1 && a_i == FULL_NEG && b_i == FULL_NEG)
        |=> (acc_o == AW_MAX && ovf_o));
    // R6: clear zeroes accumulator and flag
    a_r6_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 2'd0) |=> (acc_o == '0 && !ovf_o));
    // R9: flag is sticky until a clear
    a_r9_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !(start_i && op_i == 2'd0)) |=> ovf_o);
    // R10: idle cycles leave state untouched
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(acc_o) && $stable(frac_o) && $stable(ovf_o)));
    // R7: rounding only saturates at the positive rail
    a_r7_round_rail: assert property (@(posedge clk) disable iff (!rst_n)
        round_sat_w |-> (rnd_o == AW_MAX[AW-1:DW]));
endmodule

// File: tb/sat_mac_unit_tb_top.sv
module sat_mac_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic        valid_o;
    logic [31:0] acc_o;
    logic [15:0] rnd_o;
    logic [15:0] frac_o;
    logic        ovf_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    longint exp_acc = 0;
    bit     exp_ovf = 0;
    logic [15:0] exp_frac = '0;

    always #10 clk = ~clk;

    sat_mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .acc_o(acc_o),
        .rnd_o(rnd_o), .frac_o(frac_o), .ovf_o(ovf_o)
    );

    function automatic longint sat32(input longint v, output bit s);
        s = 1'b0;
        if (v > 64'sd2147483647) begin s = 1'b1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin s = 1'b1; return -64'sd2147483648; end
        return v;
    endfunction

    function automatic longint q31_prod(input logic [15:0] a, input logic [15:0] b, output bit s);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b)) * 2;
        return sat32(p, s);
    endfunction

    function automatic logic [15:0] q15_frac(input logic [15:0] a, input logic [15:0] b);
        longint p;
        p = (longint'($signed(a)) * longint'($signed(b))) >>> 15;
        if (p > 32767) p = 32767;
        return p[15:0];
    endfunction

    function automatic logic [15:0] q15_round(input longint acc);
        bit s;
        longint r;
        r = sat32(acc + 32768, s);
        return r[31:16];
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " acc"}, longint'(acc_o), exp_acc & 64'hFFFF_FFFF);
        check({req, " ovf"}, longint'(ovf_o), longint'(exp_ovf));
        check({req, " frac"}, longint'(frac_o), longint'(exp_frac));
        check("R7 rnd", longint'(rnd_o), longint'(q15_round(exp_acc)));
    endtask

    // Called at a negedge; returns at the negedge after the op registered.
    task automatic do_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
        bit ps, as;
        longint p;
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0;
        p = q31_prod(a, b, ps);
        exp_frac = q15_frac(a, b);
        case (op)
            2'd0: begin exp_acc = 0; exp_ovf = 0; end
            2'd1: begin exp_acc = p; exp_ovf |= ps; end
            2'd2: begin exp_acc = sat32(exp_acc + p, as); exp_ovf |= ps | as; end
            default: begin exp_acc = sat32(exp_acc - p, as); exp_ovf |= ps | as; end
        endcase
        check("R2 valid after start", longint'(valid_o), 1);
    endtask

    task automatic t_reset();
        check("R1 valid", longint'(valid_o), 0);
        check("R1 acc", longint'(acc_o), 0);
        check("R1 ovf", longint'(ovf_o), 0);
        check("R1 rnd", longint'(rnd_o), 0);
        check("R1 frac", longint'(frac_o), 0);
    endtask

    task automatic t_load();
        do_op(2'd1, 16'h4000, 16'h4000); check_all("R3 load pos");
        check("R3 quarter", longint'(acc_o), 64'h2000_0000);
        do_op(2'd1, 16'hC000, 16'h4000); check_all("R3 load mixed");
        do_op(2'd1, 16'h7FFF, 16'h7FFF); check_all("R3 load max");
        do_op(2'd1, 16'h8000, 16'h7FFF); check_all("R3 load neg");
        do_op(2'd1, 16'hFFFF, 16'hFFFF); check_all("R8 tiny");
    endtask

    task automatic t_clamp();
        do_op(2'd1, 16'h8000, 16'h8000); check_all("R3 clamp");
        check("R3 clamp value", longint'(acc_o), 64'h7FFF_FFFF);
        check("R8 frac clamp", longint'(frac_o), 64'h7FFF);
        check("R7 round rail", longint'(rnd_o), 64'h7FFF);
        do_op(2'd1, 16'h1000, 16'h1000); check_all("R9 sticky after load");
        check("R9 still set", longint'(ovf_o), 1);
        do_op(2'd0, 16'h1234, 16'h5678); check_all("R6 clear");
        check("R6 ovf cleared", longint'(ovf_o), 0);
    endtask

    task automatic t_add();
        do_op(2'd1, 16'h4000, 16'h4000); check_all("R4 base");
        do_op(2'd2, 16'h2000, 16'h2000); check_all("R4 add small");
        check("R4 no sat", longint'(ovf_o), 0);
        do_op(2'd2, 16'h7FFF, 16'h7FFF); check_all("R4 add to rail");
        check("R4 pos rail", longint'(acc_o), 64'h7FFF_FFFF);
        do_op(2'd0, 16'h0, 16'h0); check_all("R6 clear2");
    endtask

    task automatic t_sub();
        do_op(2'd3, 16'h7FFF, 16'h7FFF); check_all("R5 sub once");
        do_op(2'd3, 16'h7FFF, 16'h7FFF); check_all("R5 sub to rail");
        check("R5 neg rail", longint'(acc_o), 64'h8000_0000);
        check("R5 ovf", longint'(ovf_o), 1);
        do_op(2'd3, 16'h8000, 16'h7FFF); check_all("R5 same sign no sat");
        do_op(2'd0, 16'h0, 16'h0); check_all("R6 clear3");
        do_op(2'd2, 16'h8000, 16'h7FFF); check_all("R4 add neg");
        do_op(2'd3, 16'h8000, 16'h7FFF); check_all("R5 sub neg back");
        check("R5 back to zero", longint'(acc_o), 0);
    endtask

    task automatic t_round();
        do_op(2'd1, 16'h0100, 16'h00C0); check_all("R7 half");
        check("R7 half up", longint'(rnd_o), 2);
        do_op(2'd1, 16'hFF00, 16'h00C0); check_all("R7 neg half");
    endtask

    task automatic t_idle();
        longint acc_s;
        logic [15:0] frac_s;
        bit ovf_s;
        acc_s = longint'(acc_o); frac_s = frac_o; ovf_s = ovf_o;
        op_i = 2'd0; a_i = 16'h8000; b_i = 16'h8000;
        @(negedge clk);
        check("R2 valid drops", longint'(valid_o), 0);
        op_i = 2'd2; a_i = 16'h7FFF;
        @(negedge clk);
        check("R10 acc holds", longint'(acc_o), acc_s);
        check("R10 frac holds", longint'(frac_o), longint'(frac_s));
        check("R10 ovf holds", longint'(ovf_o), longint'(ovf_s));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_clamp();
        t_add();
        t_sub();
        t_round();
        t_idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule